// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the command half of an SD host interface. A register front end loads a 6-bit command index, a 32-bit argument and a response kind, then pulses a start request. The engine builds the 48-bit command frame and computes its CRC7 while it shifts the frame out, most significant bit first. It then either finishes at once or listens on the command line for the card's reply.

The engine paces itself on two single-cycle enables. One marks the falling edge of the SD clock, where the line is driven. The other marks the rising edge, where the reply is sampled. The command line is split into an input, an output value and an output enable, so the pad or tristate sits outside the block. A reply of 48 or 136 bits is gathered into a shift register and checked. Its useful bits are then presented as a 128-bit value for the register file. Separate one-cycle pulses mark the end of the command and the end of the reply, so a data-line controller can begin its phase from either.

Top module: `sd_cmd_engine`

## Requirements
- R1: Out of reset, the line is released (`cmd_oe` 0, `cmd_out` 1), `busy` is 0, `resp_data` is zero and no status pulse is asserted.
- R2: A start request sends 48 bits, one per falling-edge enable, MSB first. The frame is: bit 47 = 0, bit 46 = 1, bits 45..40 = index, bits 39..8 = argument, bits 7..1 = CRC7 over bits 47..8 (polynomial x^7+x^3+1, register cleared to zero), bit 0 = 1.
- R3: At the falling-edge enable after the last bit, the line is released and `cmd_end` pulses once. With response kind 0 (none), `busy` then drops and neither `resp_end` nor any error pulses.
- R4: With a response expected (kind 1 = long, kind 2 or 3 = short), the engine counts rising-edge samples after release. A low sample among the first 64 starts reception. If all 64 samples are high, `err_timeout` pulses, `busy` drops, no `resp_end` follows and `resp_data` keeps its value.
- R5: A short reply is 48 bits counted from its start bit. `resp_end` then pulses and `resp_data` becomes the reply's bits 39..8 in bits 31..0, with zeros above.
- R6: For a short reply, `err_crc` pulses with `resp_end` when reply bits 7..1 differ from the CRC7 computed over reply bits 47..8.
- R7: For a short reply, `err_index` pulses with `resp_end` when reply bits 45..40 differ from the index that was sent.
- R8: A long reply is 136 bits. `resp_data` bits 119..0 take reply bits 127..8, with zeros above. Neither `err_crc` nor `err_index` is raised for it, whatever its index and CRC fields hold.
- R9: For either reply length, `err_endbit` pulses with `resp_end` when the last reply bit is 0.
- R10: A start request while `busy` is 1 is ignored: the frame on the line and the number of `cmd_end` pulses are those of the command already running.
- R11: `cmd_out` and `cmd_oe` change only on the clock after a falling-edge enable.
- R12: `resp_data` changes only in the cycle where `resp_end` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_rise_en | input | 1 | Marks an SD clock rising edge: reply sampling point |
| sd_fall_en | input | 1 | Marks an SD clock falling edge: line update point |
| cmd_start | input | 1 | Start request, taken only while idle |
| cmd_index | input | 6 | Command index to send |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | 0 none, 1 long (136), 2 or 3 short (48) |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven onto the command line |
| cmd_oe | output | 1 | Command line output enable |
| busy | output | 1 | A command or reply is in progress |
| cmd_end | output | 1 | One-cycle pulse: command frame finished |
| resp_end | output | 1 | One-cycle pulse: reply received and checked |
| err_timeout | output | 1 | One-cycle pulse: no reply start within the window |
| err_crc | output | 1 | With `resp_end`: short reply CRC mismatch |
| err_index | output | 1 | With `resp_end`: short reply index mismatch |
| err_endbit | output | 1 | With `resp_end`: reply end bit was 0 |
| resp_data | output | 128 | Stored reply payload |

## Verification
The bench builds the engine with its default parameters: a 6-bit index, a 32-bit argument, 48- and 136-bit replies, a 64-sample window and a 128-bit result. At these sizes, a card model that waits 63 or 64 idle samples lands on either side of the timeout boundary. A full long reply can also be streamed, so the zero-extension of the 120-bit payload is checked. The card model builds each reply from the requirements, then corrupts the CRC, index or end bit one at a time, which isolates each error pulse.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_CHK
  } eng_state_t;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_t;

  localparam int          CRC_W    = 7;
  localparam logic [6:0]  CRC_POLY = 7'h09;
endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = din ^ crc[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx import sd_cmd_pkg::*; #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int HDR_W = 2 + IDX_W + ARG_W,
  parameter int PKT_W = HDR_W + CRC_W + 1,
  parameter int CNT_W = $clog2(PKT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  input  logic             step,
  output logic             bit_o,
  output logic             done
);
  logic [HDR_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crc;
  logic [CNT_W-1:0] off;
  logic [2:0]       crc_pos;

  assign done    = (cnt == CNT_W'(PKT_W));
  assign off     = cnt - CNT_W'(HDR_W);
  assign crc_pos = 3'(CRC_W - 1) - off[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= CNT_W'(PKT_W);
    end else if (load) begin
      sr  <= {2'b01, idx, arg};
      cnt <= '0;
    end else if (step && !done) begin
      sr  <= {sr[HDR_W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  sd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (load),
    .en  (step && (cnt < CNT_W'(HDR_W))),
    .din (sr[HDR_W-1]),
    .crc (crc)
  );

  always_comb begin
    if (cnt < CNT_W'(HDR_W))              bit_o = sr[HDR_W-1];
    else if (cnt < CNT_W'(HDR_W + CRC_W)) bit_o = crc[crc_pos];
    else                                  bit_o = 1'b1;
  end
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx import sd_cmd_pkg::*; #(
  parameter int LONG_W = 136,
  parameter int HDR_W  = 40,
  parameter int CNT_W  = $clog2(LONG_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [LONG_W-1:0] sh,
  output logic [CNT_W-1:0]  cnt,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (en) begin
      sh  <= {sh[LONG_W-2:0], din};
      cnt <= cnt + 1'b1;
    end
  end

  sd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .en  (en && (cnt < CNT_W'(HDR_W))),
    .din (din),
    .crc (crc)
  );
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine import sd_cmd_pkg::*; #(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int SHORT_W   = 48,
  parameter int LONG_W    = 136,
  parameter int RESP_W    = 128,
  parameter int RESP_WAIT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd_rise_en,
  input  logic              sd_fall_en,
  input  logic              cmd_start,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [1:0]        resp_kind,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              cmd_end,
  output logic              resp_end,
  output logic              err_timeout,
  output logic              err_crc,
  output logic              err_index,
  output logic              err_endbit,
  output logic [RESP_W-1:0] resp_data
);
  localparam int HDR_W     = 2 + IDX_W + ARG_W;
  localparam int WAIT_W    = $clog2(RESP_WAIT + 1);
  localparam int RX_CNT_W  = $clog2(LONG_W + 1);
  localparam int LONG_TOP  = LONG_W - 3 - IDX_W;
  localparam int SHORT_TOP = SHORT_W - 3 - IDX_W;

  eng_state_t          state;
  rsp_kind_t           kind_q;
  logic [IDX_W-1:0]    idx_q;
  logic [WAIT_W-1:0]   wait_cnt;
  logic                tx_bit, tx_done, tx_step, tx_load;
  logic                rx_en;
  logic [LONG_W-1:0]   rx_sh;
  logic [RX_CNT_W-1:0] rx_cnt, rx_len;
  logic [CRC_W-1:0]    rx_crc;

  assign busy    = (state != ST_IDLE);
  assign tx_load = (state == ST_IDLE) && cmd_start;
  assign tx_step = (state == ST_TX) && sd_fall_en && !tx_done;
  assign rx_en   = sd_rise_en &&
                   (((state == ST_WAIT) && !cmd_in) || (state == ST_RX));
  assign rx_len  = (kind_q == RSP_LONG) ? RX_CNT_W'(LONG_W) : RX_CNT_W'(SHORT_W);

  sd_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .load  (tx_load),
    .idx   (cmd_index),
    .arg   (cmd_arg),
    .step  (tx_step),
    .bit_o (tx_bit),
    .done  (tx_done)
  );

  sd_cmd_rx #(.LONG_W(LONG_W), .HDR_W(HDR_W), .CNT_W(RX_CNT_W)) u_rx (
    .clk (clk),
    .rst (rst),
    .clr (tx_load),
    .en  (rx_en),
    .din (cmd_in),
    .sh  (rx_sh),
    .cnt (rx_cnt),
    .crc (rx_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind_q      <= RSP_NONE;
      idx_q       <= '0;
      wait_cnt    <= '0;
      cmd_out     <= 1'b1;
      cmd_oe      <= 1'b0;
      cmd_end     <= 1'b0;
      resp_end    <= 1'b0;
      err_timeout <= 1'b0;
      err_crc     <= 1'b0;
      err_index   <= 1'b0;
      err_endbit  <= 1'b0;
      resp_data   <= '0;
    end else begin
      cmd_end     <= 1'b0;
      resp_end    <= 1'b0;
      err_timeout <= 1'b0;
      err_crc     <= 1'b0;
      err_index   <= 1'b0;
      err_endbit  <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_start) begin
          idx_q  <= cmd_index;
          kind_q <= rsp_kind_t'(resp_kind);
          state  <= ST_TX;
        end
        ST_TX: if (sd_fall_en) begin
          if (!tx_done) begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx_bit;
          end else begin
            cmd_oe   <= 1'b0;
            cmd_out  <= 1'b1;
            cmd_end  <= 1'b1;
            wait_cnt <= '0;
            state    <= (kind_q == RSP_NONE) ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: if (sd_rise_en) begin
          if (!cmd_in) state <= ST_RX;
          else if (wait_cnt == WAIT_W'(RESP_WAIT - 1)) begin
            err_timeout <= 1'b1;
            state       <= ST_IDLE;
          end else wait_cnt <= wait_cnt + 1'b1;
        end
        ST_RX: if (sd_rise_en && (rx_cnt == rx_len - 1'b1)) state <= ST_CHK;
        ST_CHK: begin
          resp_end   <= 1'b1;
          err_endbit <= !rx_sh[0];
          if (kind_q == RSP_LONG) begin
            resp_data <= RESP_W'(rx_sh[LONG_TOP:CRC_W+1]);
          end else begin
            resp_data <= RESP_W'(rx_sh[SHORT_TOP:CRC_W+1]);
            err_crc   <= (rx_sh[CRC_W:1] != rx_crc);
            err_index <= (rx_sh[SHORT_W-3 -: IDX_W] != idx_q);
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  drive_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sd_fall_en)) |-> ($stable(cmd_out) && $stable(cmd_oe)));

  // R12
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !resp_end) |-> $stable(resp_data));

  // R3
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_end && resp_end));

  // R6
  err_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (err_crc || err_index || err_endbit) |-> resp_end);

  // R4
  timeout_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> (!resp_end && !busy));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_oe);

  // R10
  cmd_end_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cmd_end) |-> $past(busy));
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         sd_rise_en = 1'b0, sd_fall_en = 1'b0;
  logic         cmd_start = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   resp_kind = '0;
  logic         cmd_in = 1'b1;
  logic         cmd_out, cmd_oe, busy, cmd_end, resp_end;
  logic         err_timeout, err_crc, err_index, err_endbit;
  logic [127:0] resp_data;

  always #2 clk = ~clk;

  sd_cmd_engine u_dut (
    .clk(clk), .rst(rst), .sd_rise_en(sd_rise_en), .sd_fall_en(sd_fall_en),
    .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .resp_kind(resp_kind), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .cmd_end(cmd_end), .resp_end(resp_end),
    .err_timeout(err_timeout), .err_crc(err_crc), .err_index(err_index),
    .err_endbit(err_endbit), .resp_data(resp_data)
  );

  int nchk = 0, nerr = 0;
  int n_cend, n_rend, n_to;
  logic s_crc, s_idx, s_end;
  logic [47:0]  cap;
  int           ncap, kcard, rlen, rdly;
  logic [135:0] rv;

  always @(negedge clk) begin
    if (cmd_end) n_cend++;
    if (err_timeout) n_to++;
    if (resp_end) begin
      n_rend++;
      s_crc = err_crc; s_idx = err_index; s_end = err_endbit;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7f(input logic [39:0] v);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic card_bit(input int k);
    if (k < rdly) return 1'b1;
    if (k - rdly < rlen) return rv[rlen - 1 - (k - rdly)];
    return 1'b1;
  endfunction

  task automatic sd_period(input bit inj);
    @(negedge clk); sd_rise_en = 1'b1; sd_fall_en = 1'b0; cmd_start = 1'b0;
    if (cmd_oe && ncap < 48) begin cap = {cap[46:0], cmd_out}; ncap++; end
    @(negedge clk); sd_rise_en = 1'b0;
    if (inj) begin cmd_start = 1'b1; cmd_index = cmd_index ^ 6'h2A; end
    @(negedge clk); sd_fall_en = 1'b1; cmd_start = 1'b0;
    if (ncap == 48) begin cmd_in = card_bit(kcard); kcard++; end
    @(negedge clk); sd_fall_en = 1'b0;
  endtask

  task automatic run_txn(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] kind, input int dly, input bit bad_crc,
                         input bit bad_idx, input bit bad_end, input bit inject);
    logic [47:0]  pkt;
    logic [127:0] prev, exp_data;
    logic [119:0] pay;
    logic [31:0]  st;
    logic [5:0]   ridx;
    logic [6:0]   rc;
    bit e_crc = 0, e_idx = 0;
    pkt = {2'b01, idx, arg, crc7f({2'b01, idx, arg}), 1'b1};
    prev = resp_data;
    if (kind == 2'd1) begin
      pay  = {$urandom, $urandom, $urandom, $urandom};
      rv   = {2'b00, 6'h3F, pay, 7'($urandom), ~bad_end};
      rlen = 136;
      exp_data = {8'h00, pay};
    end else begin
      st   = $urandom;
      ridx = bad_idx ? (idx ^ 6'h01) : idx;
      rc   = crc7f({2'b00, ridx, st}) ^ (bad_crc ? 7'h01 : 7'h00);
      rv   = '0;
      rv[47:0] = {2'b00, ridx, st, rc, ~bad_end};
      rlen = 48;
      exp_data = {96'h0, st};
      e_crc = bad_crc; e_idx = bad_idx;
    end
    rdly = (kind == 2'd0) ? 100000 : dly;
    ncap = 0; cap = '0; kcard = 0; cmd_in = 1'b1;
    n_cend = 0; n_rend = 0; n_to = 0; s_crc = 0; s_idx = 0; s_end = 0;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; resp_kind = kind; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    for (int np = 0; np < 800; np++) begin
      sd_period(inject && np == 10);
      if (np > 2 && !busy) break;
    end
    sd_period(1'b0); sd_period(1'b0);
    chk(cap == pkt && ncap == 48, inject ? "R10" : "R2", 128'(cap), 128'(pkt));
    chk(n_cend == 1 && !busy, "R3", 128'(n_cend), 128'd1);
    if (kind == 2'd0) begin
      chk(n_rend == 0 && n_to == 0, "R3", 128'(n_rend + n_to), 128'd0);
      chk(resp_data == prev, "R12", resp_data, prev);
    end else if (dly >= 64) begin
      chk(n_to == 1 && n_rend == 0, "R4", 128'({n_to, n_rend}), 128'({32'd1, 32'd0}));
      chk(resp_data == prev, "R4", resp_data, prev);
    end else begin
      chk(n_rend == 1 && n_to == 0, kind == 2'd1 ? "R8" : "R5", 128'(n_rend), 128'd1);
      chk(resp_data == exp_data, kind == 2'd1 ? "R8" : "R5", resp_data, exp_data);
      chk(s_crc == e_crc, kind == 2'd1 ? "R8" : "R6", 128'(s_crc), 128'(e_crc));
      chk(s_idx == e_idx, kind == 2'd1 ? "R8" : "R7", 128'(s_idx), 128'(e_idx));
      chk(s_end == bad_end, "R9", 128'(s_end), 128'(bad_end));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1C));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!cmd_oe && cmd_out && !busy && resp_data == '0 && !cmd_end && !resp_end
        && !err_timeout, "R1", {cmd_oe, cmd_out, busy}, 128'b010);
    run_txn(6'd0,  32'h0000_0000, 2'd0, 0,  0, 0, 0, 0);   // R3
    run_txn(6'd17, 32'h1234_5678, 2'd2, 5,  0, 0, 0, 0);   // R5
    run_txn(6'd8,  32'h0000_01AA, 2'd3, 63, 0, 0, 0, 0);   // R4 last window sample
    run_txn(6'd55, 32'hDEAD_BEEF, 2'd2, 64, 0, 0, 0, 0);   // R4 timeout
    run_txn(6'd13, 32'hFFFF_FFFF, 2'd2, 2,  1, 0, 0, 0);   // R6
    run_txn(6'd52, 32'h8000_0001, 2'd2, 0,  0, 1, 0, 0);   // R7
    run_txn(6'd3,  32'h0F0F_F0F0, 2'd2, 1,  0, 0, 1, 0);   // R9
    run_txn(6'd2,  32'h0000_0000, 2'd1, 4,  0, 0, 0, 0);   // R8
    run_txn(6'd9,  32'hA5A5_5A5A, 2'd1, 7,  0, 0, 1, 0);   // R8 R9
    run_txn(6'd1,  32'hCAFE_0042, 2'd1, 64, 0, 0, 0, 0);   // R4 long
    run_txn(6'd41, 32'h7777_0000, 2'd2, 3,  0, 0, 0, 1);   // R10
    for (int i = 0; i < 14; i++) begin
      logic [1:0] k = 2'($urandom_range(0, 3));
      int d = (i % 5 == 4) ? 64 : $urandom_range(0, 20);
      run_txn(6'($urandom), $urandom, k, d, ($urandom_range(0, 3) == 0),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule